// File: doc/BRIEF.md
# Oscillator Stabilization Wait Timer

This block holds back a clock-ready indication until a freshly enabled main oscillator has had time to settle. It counts main-clock cycles from the moment the oscillator enable goes high. When a programmable interval has passed, it raises a sticky ready flag. A 4-bit select code sets the interval. The code is decoded on an exponential scale, so each step up in the code roughly doubles the wait.

The select code sits in a small register behind a simple write port. That register is write-protected while a wait is running. A write is taken only when the oscillator enable is low or the ready flag is already set. Software can read the register back on `sel_q`. Lowering the enable stops any wait that is in progress and clears the ready flag.

Top module: `osc_settle_timer`

## Requirements
- R1: After reset, `sel_q` reads 4'hF and `ready` is 0.
- R2: For select code k from 3 to 15, the decoded wait T is 2^(k-1) - 2 cycles. `ready` goes to 1 on the (T+1)-th rising edge after the start edge. The start edge is the first rising edge at which `osc_en` is sampled 1 after being sampled 0.
- R3: Select codes 0, 1 and 2 decode to T = 0. `ready` goes to 1 on the first rising edge after the start edge.
- R4: The start edge clears `ready`, and `ready` stays 0 until the wait completes.
- R5: A write (`sel_we` = 1) sampled while `osc_en` = 1 and `ready` = 0 is ignored, and `sel_q` keeps its value.
- R6: A write sampled while `osc_en` = 0 or `ready` = 1 loads `sel_wdata` into `sel_q` at that edge.
- R7: When `osc_en` is sampled 0, `ready` is 0 after that edge, and any wait in progress is dropped.
- R8: Once set, `ready` stays 1 for as long as `osc_en` stays 1.
- R9: With a 250 ns main-clock period (4 MHz), code 15 gives a decoded wait of about 4.10 ms (16382 cycles) and code 3 gives 0.5 µs (2 cycles).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_en | input | 1 | Oscillator enable; a rise starts a wait, low aborts it |
| sel_we | input | 1 | Write strobe for the select register |
| sel_wdata | input | 4 | Select code to write |
| sel_q | output | 4 | Current select code |
| ready | output | 1 | Sticky, registered settling-done flag |

## Verification
The start edge is the first rising edge that samples the enable high. `ready` is due exactly T+1 edges after that start edge. A write to the select register shows on `sel_q` one edge after the write is sampled, and dropping the enable clears `ready` one edge later. The bench drives inputs on falling edges and samples 2 ns after each rising edge. Its monitor counts rising edges from the start edge to the first edge at which `ready` is seen high. It compares that count with the value the driver queued. Protection and abort checks look at `sel_q` and `ready` on the falling edge that follows the stimulus edge.

// File: rtl/osw_pkg.sv
package osw_pkg;

  // Settling cycles for a select code: 2^(code-1) - 2, floor at zero.
  function automatic int unsigned settle_count(input logic [3:0] code);
    int unsigned k;
    k = int'(code);
    if (k <= 2) return 0;
    return (32'd1 << (k - 1)) - 32'd2;
  endfunction

endpackage

// File: rtl/osw_sel_reg.sv
module osw_sel_reg #(
  parameter int SEL_W = 4,
  parameter logic [SEL_W-1:0] RST_CODE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             allow,
  input  logic [SEL_W-1:0] wdata,
  output logic [SEL_W-1:0] q,
  output logic             wr_accept
);
  assign wr_accept = we & allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= RST_CODE;
    else if (wr_accept) q <= wdata;
  end
endmodule

// File: rtl/osw_edge.sv
module osw_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/osw_wait_ctr.sv
module osw_wait_ctr #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             start,
  input  logic [CNT_W-1:0] target,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tgt;
  logic             at_end;

  assign at_end = (cnt == tgt);
  assign done   = busy & at_end & run_en & ~start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      tgt  <= '0;
    end else if (!run_en) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      tgt  <= target;
    end else if (busy) begin
      if (at_end) busy <= 1'b0;
      else        cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
  parameter int SEL_W = 4,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  output logic [SEL_W-1:0] sel_q,
  output logic             ready
);
  import osw_pkg::*;

  localparam logic [SEL_W-1:0] RST_CODE = {SEL_W{1'b1}};

  logic             start_evt;
  logic             done_evt;
  logic             busy;
  logic             wr_accept;
  logic             wr_allow;
  logic [CNT_W-1:0] target;

  assign wr_allow = ~osc_en | ready;
  assign target   = CNT_W'(settle_count(4'(sel_q)));

  osw_sel_reg #(.SEL_W(SEL_W), .RST_CODE(RST_CODE)) u_sel (
    .clk(clk), .rst_n(rst_n), .we(sel_we), .allow(wr_allow),
    .wdata(sel_wdata), .q(sel_q), .wr_accept(wr_accept)
  );

  osw_edge u_edge (
    .clk(clk), .rst_n(rst_n), .level(osc_en), .rise(start_evt)
  );

  osw_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run_en(osc_en), .start(start_evt),
    .target(target), .busy(busy), .done(done_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ready <= 1'b0;
    else if (!osc_en || start_evt)  ready <= 1'b0;
    else if (done_evt)              ready <= 1'b1;
  end
endmodule

// File: rtl/osw_chk.sv
module osw_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_en,
  input logic             sel_we,
  input logic [SEL_W-1:0] sel_wdata,
  input logic [SEL_W-1:0] sel_q,
  input logic             ready,
  input logic             start_evt,
  input logic             busy,
  input logic             done_evt,
  input logic             wr_accept
);
  // R4
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!ready && busy));

  // R2
  rise_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(done_evt));

  // R5
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && osc_en && !ready) |=> $stable(sel_q));

  // R6
  open_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && (!osc_en || ready)) |=> (sel_q == $past(sel_wdata)));

  // R6
  accept_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> sel_we);

  // R7
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> (!ready && !busy));

  // R8
  sticky_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && osc_en) |=> ready);
endmodule

bind osc_settle_timer osw_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .sel_we(sel_we),
  .sel_wdata(sel_wdata), .sel_q(sel_q), .ready(ready),
  .start_evt(start_evt), .busy(busy), .done_evt(done_evt),
  .wr_accept(wr_accept)
);

// File: tb/sim_osc_settle_timer.sv
`timescale 1ns/1ps
module sim_osc_settle_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       sel_we = 1'b0;
  logic [3:0] sel_wdata = 4'h0;
  logic [3:0] sel_q;
  logic       ready;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int popped = 0;
  bit finished = 0;

  int exp_q[$];
  int code_q[$];

  always #5 clk = ~clk;

  osc_settle_timer u0 (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .sel_we(sel_we),
    .sel_wdata(sel_wdata), .sel_q(sel_q), .ready(ready)
  );

  function automatic int model_wait(input int code);
    int p;
    if (code < 3) return 0;
    p = 1;
    for (int i = 1; i < code; i++) p = p * 2;
    return p - 2;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Monitor: counts edges from start edge to the ready edge.
  bit prev_en = 0;
  bit active = 0;
  int meas = 0;
  always @(posedge clk) begin
    #2;
    if (!rst_n || !osc_en) begin
      active = 0;
    end else if (!prev_en) begin
      active = 1;
      meas = 0;
    end else if (active) begin
      meas++;
      if (ready) begin
        int e, c;
        active = 0;
        if (exp_q.size() == 0) begin
          check("R4 unexpected ready", 1, 0);
        end else begin
          e = exp_q.pop_front();
          c = code_q.pop_front();
          check((c < 3) ? "R3 latency" : "R2 latency", meas, e);
          if (c == 15) check("R9 4.10ms", ((meas - 1) * 250 > 4_090_000 &&
                                          (meas - 1) * 250 < 4_110_000) ? 1 : 0, 1);
          if (c == 3)  check("R9 0.5us", (meas - 1) * 250, 500);
          popped++;
        end
      end
    end
    prev_en = rst_n && osc_en;
  end

  task automatic write_sel(input int code);
    @(negedge clk);
    sel_we = 1'b1;
    sel_wdata = 4'(code);
    @(negedge clk);
    sel_we = 1'b0;
  endtask

  task automatic run_wait(input int code, input int next_code);
    write_sel(code);
    check("R6 write while disabled", int'(sel_q), code);
    exp_q.push_back(model_wait(code) + 1);
    code_q.push_back(code);
    pushed++;
    @(negedge clk);
    osc_en = 1'b1;
    wait (popped == pushed);
    repeat (4) @(negedge clk);
    check("R8 ready held", int'(ready), 1);
    write_sel(next_code);
    check("R6 write while ready", int'(sel_q), next_code);
    osc_en = 1'b0;
    @(negedge clk);
    check("R7 ready cleared", int'(ready), 0);
  endtask

  initial begin
    #(200000 * 10);
    check("watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset sel", int'(sel_q), 15);
    check("R1 reset ready", int'(ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sel after release", int'(sel_q), 15);

    run_wait(0, 1);
    run_wait(1, 2);
    run_wait(2, 3);
    run_wait(3, 4);
    run_wait(4, 7);
    run_wait(7, 10);
    run_wait(10, 15);
    run_wait(15, 15);

    // R5 and R7: write during a wait, then abort.
    @(negedge clk);
    osc_en = 1'b1;
    repeat (100) @(negedge clk);
    check("R4 ready low during wait", int'(ready), 0);
    write_sel(3);
    check("R5 write ignored", int'(sel_q), 15);
    osc_en = 1'b0;
    @(negedge clk);
    check("R7 abort ready", int'(ready), 0);
    repeat (20) @(negedge clk);
    check("R7 no late ready", int'(ready), 0);
    write_sel(5);
    check("R6 write after abort", int'(sel_q), 5);

    // R4: restart after a completed wait clears ready at start edge.
    run_wait(5, 5);
    check("R7 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule